// File: doc/BRIEF.md
# PLL Setting to Bus Frequency Calculator

This block turns the contents of a PLL parameter word, a clock-select word and a set of strap inputs into two numbers in hertz. The first is the frequency that the PLL would produce with those settings. The second is the peripheral bus frequency derived from it. It models the arithmetic that firmware would perform on these registers. It does not generate any clock.

The layout of the PLL word is fixed at elaboration by a parameter, which picks one of three variants:

- **Layout A** uses a programmed flag. When the flag is clear, the frequency comes from a strap-indexed table.
- **Layout B** has a 6-bit post divider, an 8-bit multiplier and a 5-bit pre divider.
- **Layout C** has a 4-bit post divider, a 6-bit pre divider and a 13-bit multiplier.

A single restoring divider is shared by every division the calculation needs. The divisions run one after another in a fixed order, and each quotient is truncated before it feeds the next stage.

To use the block, present the three words and pulse `start` for one cycle while the block is idle. Some tens of cycles later `done` pulses for one cycle. From that cycle on, `pll_hz` and `bus_hz` hold the new results until the next calculation completes.

Top module: `pll_bus_freq_calc`

## Requirements
- R1: After a synchronous reset, `pll_hz`, `bus_hz` and `done` are all zero.
- R2: The reference frequency is chosen as follows. If strap bit 23 is set, or the `FORCE_25M` parameter is 1, it is 25 000 000. Otherwise, if strap bit 18 is set, it is 48 000 000. Otherwise it is 24 000 000. Bit 23 takes priority over bit 18.
- R3: When PLL word bit 25 (power-down) is set, `pll_hz` and `bus_hz` are 0 in every layout, whatever the other bits hold.
- R4: When bit 24 (bypass) is set and bit 25 is clear, `pll_hz` equals the reference frequency. In layout A this applies only when bit 23 (programmed) is also set.
- R5: In layout B, p = bits[18:13], m = bits[12:5] and n = bits[4:0]. `pll_hz` is ref × (((m+1)/(n+1))/(p+1)), with each quotient truncated. The product is kept modulo 2^32.
- R6: In layout C, p = bits[22:19], n = bits[18:13] and m = bits[12:0]. The staged formula of R5 applies.
- R7: In layout A with bit 23 set and bit 24 clear, n = bits[10:5], od = bit 4 and d = bits[3:0]. `pll_hz` is ref × ((2−od) × ((n+2)/(d+1))), with the quotient truncated.
- R8: In layout A with bit 23 clear, `pll_hz` is a table value in MHz × 10^6.
  - The table column is strap bits[9:8].
  - The table row is strap bit 23.
  - Row 0 holds 384, 360, 336 and 408.
  - Row 1 holds 400, 375, 350 and 425.
- R9: `bus_hz` is (`pll_hz` / (clock-select bits[25:23] + 1)) / F, truncated at each step. F is 2 for layout A and 4 for layouts B and C.
- R10: `done` is high for exactly one cycle per accepted `start`. The outputs change only in that cycle and otherwise hold their last results.
- R11: A `start` that arrives while a calculation is in progress is ignored. It neither alters the pending results nor produces a second `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a calculation; taken only when idle |
| pll_word | input | 32 | PLL parameter word |
| clksel_word | input | 32 | Clock-select word holding the bus divider field |
| strap_word | input | 32 | Strap inputs: reference-frequency flags and table select |
| pll_hz | output | 32 | Computed PLL output frequency in Hz |
| bus_hz | output | 32 | Computed bus frequency in Hz |
| done | output | 1 | One-cycle pulse when new results are on the outputs |

## Verification
The hardest situation to reach from the ports is a second `start` landing in the middle of a calculation. The divider is busy and the latched words must not be disturbed.

The bench reaches it by launching one calculation and presenting a different word set with `start` a few cycles later. It then checks three things:
- The results match the first word set.
- Exactly one `done` appears.
- The outputs stay still for hundreds of cycles afterwards.

Truncation between the stages is the second hard case. The bench reaches it with ratios chosen so that the staged quotient differs from the exact quotient.

// File: rtl/pllcalc_pkg.sv
package pllcalc_pkg;

    localparam int FREQ_W = 32;
    localparam int WORD_W = 32;

    localparam logic [FREQ_W-1:0] HZ_24M = FREQ_W'(24_000_000);
    localparam logic [FREQ_W-1:0] HZ_25M = FREQ_W'(25_000_000);
    localparam logic [FREQ_W-1:0] HZ_48M = FREQ_W'(48_000_000);
    localparam logic [FREQ_W-1:0] MHZ    = FREQ_W'(1_000_000);

    typedef enum logic [1:0] {
        LAYOUT_A = 2'd0,
        LAYOUT_B = 2'd1,
        LAYOUT_C = 2'd2
    } layout_e;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_DIRECT = 2'd1,
        MODE_RATIO  = 2'd2
    } mode_e;

    // Everything the controller needs, decoded at start.
    typedef struct packed {
        mode_e             mode;
        logic              two_stage;
        logic              dbl;
        logic [FREQ_W-1:0] ref_hz;
        logic [FREQ_W-1:0] direct_hz;
        logic [FREQ_W-1:0] num1;
        logic [FREQ_W-1:0] den1;
        logic [FREQ_W-1:0] den2;
        logic [FREQ_W-1:0] bus_den;
    } plan_t;

    // The 25 MHz row is the 24/48 MHz row scaled by 25/24.
    function automatic logic [FREQ_W-1:0] table_mhz(input logic row25,
                                                    input logic [1:0] sel);
        logic [FREQ_W-1:0] base;
        case (sel)
            2'd0:    base = FREQ_W'(384);
            2'd1:    base = FREQ_W'(360);
            2'd2:    base = FREQ_W'(336);
            default: base = FREQ_W'(408);
        endcase
        return row25 ? (base * FREQ_W'(25)) / FREQ_W'(24) : base;
    endfunction

endpackage

// File: rtl/pllcalc_decode.sv
module pllcalc_decode
    import pllcalc_pkg::*;
#(
    parameter layout_e LAYOUT        = LAYOUT_B,
    parameter bit      FORCE_25M     = 1'b0,
    parameter int      OFF_BIT       = 25,
    parameter int      BYPASS_BIT    = 24,
    parameter int      PROG_BIT      = 23,
    parameter int      STRAP_25M_BIT = 23,
    parameter int      STRAP_48M_BIT = 18,
    parameter int      STRAP_SEL_LSB = 8,
    parameter int      CLKDIV_LSB    = 23,
    parameter int      CLKDIV_W      = 3
) (
    input  logic [WORD_W-1:0] pll_word,
    input  logic [WORD_W-1:0] clksel_word,
    input  logic [WORD_W-1:0] strap_word,
    output plan_t             plan
);

    logic [FREQ_W-1:0] ref_hz;
    logic [FREQ_W-1:0] bus_den;

    always_comb begin
        if (strap_word[STRAP_25M_BIT] || FORCE_25M)
            ref_hz = HZ_25M;
        else if (strap_word[STRAP_48M_BIT])
            ref_hz = HZ_48M;
        else
            ref_hz = HZ_24M;
    end

    assign bus_den = FREQ_W'(clksel_word[CLKDIV_LSB +: CLKDIV_W]) + FREQ_W'(1);

    generate
        if (LAYOUT == LAYOUT_A) begin : g_layout_a
            always_comb begin
                plan           = '0;
                plan.ref_hz    = ref_hz;
                plan.bus_den   = bus_den;
                plan.den2      = FREQ_W'(1);
                plan.mode      = MODE_DIRECT;
                if (pll_word[OFF_BIT]) begin
                    plan.mode = MODE_OFF;
                end else if (pll_word[PROG_BIT]) begin
                    if (pll_word[BYPASS_BIT]) begin
                        plan.direct_hz = ref_hz;
                    end else begin
                        plan.mode      = MODE_RATIO;
                        plan.num1      = FREQ_W'(pll_word[10:5]) + FREQ_W'(2);
                        plan.den1      = FREQ_W'(pll_word[3:0]) + FREQ_W'(1);
                        plan.dbl       = ~pll_word[4];
                        plan.two_stage = 1'b0;
                    end
                end else begin
                    plan.direct_hz = table_mhz(strap_word[STRAP_25M_BIT],
                                               strap_word[STRAP_SEL_LSB +: 2]) * MHZ;
                end
            end
        end else begin : g_layout_bc
            logic [FREQ_W-1:0] fp, fm, fn;
            if (LAYOUT == LAYOUT_B) begin : g_b
                assign fp = FREQ_W'(pll_word[18:13]);
                assign fm = FREQ_W'(pll_word[12:5]);
                assign fn = FREQ_W'(pll_word[4:0]);
            end else begin : g_c
                assign fp = FREQ_W'(pll_word[22:19]);
                assign fn = FREQ_W'(pll_word[18:13]);
                assign fm = FREQ_W'(pll_word[12:0]);
            end
            always_comb begin
                plan         = '0;
                plan.ref_hz  = ref_hz;
                plan.bus_den = bus_den;
                plan.den2    = fp + FREQ_W'(1);
                plan.mode    = MODE_DIRECT;
                if (pll_word[OFF_BIT]) begin
                    plan.mode = MODE_OFF;
                end else if (pll_word[BYPASS_BIT]) begin
                    plan.direct_hz = ref_hz;
                end else begin
                    plan.mode      = MODE_RATIO;
                    plan.num1      = fm + FREQ_W'(1);
                    plan.den1      = fn + FREQ_W'(1);
                    plan.two_stage = 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/pllcalc_divider.sv
module pllcalc_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic         valid,
    output logic         busy
);

    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q, quo_q, dvs_q, dnd_q;
    logic [CW-1:0] cnt_q;
    logic [W:0]    shifted, diff;
    logic          fits;

    assign shifted = {rem_q, quo_q[W-1]};
    assign diff    = shifted - {1'b0, dvs_q};
    assign fits    = ~diff[W];

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
            dnd_q <= '0;
            cnt_q <= '0;
            busy  <= 1'b0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (go && !busy) begin
                rem_q <= '0;
                quo_q <= dividend;
                dvs_q <= divisor;
                dnd_q <= dividend;
                cnt_q <= CW'(W);
                busy  <= 1'b1;
            end else if (busy) begin
                rem_q <= fits ? diff[W-1:0] : shifted[W-1:0];
                quo_q <= {quo_q[W-2:0], fits};
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    busy  <= 1'b0;
                    valid <= 1'b1;
                end
            end
        end
    end

    assign quotient = quo_q;

    // Staged quotients feed the R5 formula; each must be an exact floor division.
    assert_div_exact_R5: assert property (@(posedge clk) disable iff (rst)
        valid |-> (({{W{1'b0}}, quo_q} * {{W{1'b0}}, dvs_q} + {{W{1'b0}}, rem_q})
                   == {{W{1'b0}}, dnd_q}) && (dvs_q == '0 || rem_q < dvs_q));

endmodule

// File: rtl/pll_bus_freq_calc.sv
module pll_bus_freq_calc
    import pllcalc_pkg::*;
#(
    parameter layout_e LAYOUT        = LAYOUT_B,
    parameter bit      FORCE_25M     = 1'b0,
    parameter int      OFF_BIT       = 25,
    parameter int      BYPASS_BIT    = 24,
    parameter int      PROG_BIT      = 23,
    parameter int      STRAP_25M_BIT = 23,
    parameter int      STRAP_48M_BIT = 18,
    parameter int      STRAP_SEL_LSB = 8,
    parameter int      CLKDIV_LSB    = 23,
    parameter int      CLKDIV_W      = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WORD_W-1:0] pll_word,
    input  logic [WORD_W-1:0] clksel_word,
    input  logic [WORD_W-1:0] strap_word,
    output logic [FREQ_W-1:0] pll_hz,
    output logic [FREQ_W-1:0] bus_hz,
    output logic              done
);

    localparam logic [FREQ_W-1:0] BUS_FIXED =
        (LAYOUT == LAYOUT_A) ? FREQ_W'(2) : FREQ_W'(4);

    typedef enum logic [2:0] {
        ST_IDLE, ST_RATIO1, ST_RATIO2, ST_BUS1, ST_BUS2
    } state_e;

    state_e            state;
    plan_t             plan_d, plan_q;
    logic [FREQ_W-1:0] pll_w;
    logic              div_go, div_valid, div_busy;
    logic [FREQ_W-1:0] div_a, div_b, div_q;
    logic [FREQ_W-1:0] mul_in, prod;

    pllcalc_decode #(
        .LAYOUT(LAYOUT), .FORCE_25M(FORCE_25M), .OFF_BIT(OFF_BIT),
        .BYPASS_BIT(BYPASS_BIT), .PROG_BIT(PROG_BIT),
        .STRAP_25M_BIT(STRAP_25M_BIT), .STRAP_48M_BIT(STRAP_48M_BIT),
        .STRAP_SEL_LSB(STRAP_SEL_LSB), .CLKDIV_LSB(CLKDIV_LSB), .CLKDIV_W(CLKDIV_W)
    ) u_decode (
        .pll_word(pll_word), .clksel_word(clksel_word),
        .strap_word(strap_word), .plan(plan_d)
    );

    pllcalc_divider #(.W(FREQ_W)) u_div (
        .clk(clk), .rst(rst), .go(div_go), .dividend(div_a), .divisor(div_b),
        .quotient(div_q), .valid(div_valid), .busy(div_busy)
    );

    // Product truncated to FREQ_W bits.
    assign mul_in = plan_q.dbl ? {div_q[FREQ_W-2:0], 1'b0} : div_q;
    assign prod   = plan_q.ref_hz * mul_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            plan_q <= '0;
            pll_w  <= '0;
            pll_hz <= '0;
            bus_hz <= '0;
            done   <= 1'b0;
            div_go <= 1'b0;
            div_a  <= '0;
            div_b  <= '0;
        end else begin
            div_go <= 1'b0;
            done   <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    plan_q <= plan_d;
                    div_go <= 1'b1;
                    if (plan_d.mode == MODE_RATIO) begin
                        div_a <= plan_d.num1;
                        div_b <= plan_d.den1;
                        state <= ST_RATIO1;
                    end else begin
                        pll_w <= plan_d.direct_hz;
                        div_a <= plan_d.direct_hz;
                        div_b <= plan_d.bus_den;
                        state <= ST_BUS1;
                    end
                end
                ST_RATIO1: if (div_valid) begin
                    div_go <= 1'b1;
                    if (plan_q.two_stage) begin
                        div_a <= div_q;
                        div_b <= plan_q.den2;
                        state <= ST_RATIO2;
                    end else begin
                        pll_w <= prod;
                        div_a <= prod;
                        div_b <= plan_q.bus_den;
                        state <= ST_BUS1;
                    end
                end
                ST_RATIO2: if (div_valid) begin
                    div_go <= 1'b1;
                    pll_w  <= prod;
                    div_a  <= prod;
                    div_b  <= plan_q.bus_den;
                    state  <= ST_BUS1;
                end
                ST_BUS1: if (div_valid) begin
                    div_go <= 1'b1;
                    div_a  <= div_q;
                    div_b  <= BUS_FIXED;
                    state  <= ST_BUS2;
                end
                ST_BUS2: if (div_valid) begin
                    pll_hz <= pll_w;
                    bus_hz <= div_q;
                    done   <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_go_idle_R10: assert property (@(posedge clk) disable iff (rst)
        div_go |-> !div_busy);

    assert_busy_ignores_start_R11: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> $stable(plan_q));

    assert_bus_below_pll_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (bus_hz <= pll_hz));

    assert_off_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (done && plan_q.mode == MODE_OFF) |-> (pll_hz == '0 && bus_hz == '0));

endmodule

// File: tb/tb_pll_bus_freq_calc.sv
module tb_pll_bus_freq_calc;
    import pllcalc_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] pw = '0, cw = '0, sw = '0;
    logic [31:0] ph [3];
    logic [31:0] bh [3];
    logic        dn [3];
    int          checks = 0;
    int          fails = 0;
    int          cyc = 0;

    always #2 clk = ~clk; // 250 MHz

    // index 0: layout A, 1: layout B, 2: layout C (25 MHz forced)
    pll_bus_freq_calc #(.LAYOUT(LAYOUT_A)) dut_a (
        .clk(clk), .rst(rst), .start(start), .pll_word(pw), .clksel_word(cw),
        .strap_word(sw), .pll_hz(ph[0]), .bus_hz(bh[0]), .done(dn[0]));
    pll_bus_freq_calc #(.LAYOUT(LAYOUT_B)) dut (
        .clk(clk), .rst(rst), .start(start), .pll_word(pw), .clksel_word(cw),
        .strap_word(sw), .pll_hz(ph[1]), .bus_hz(bh[1]), .done(dn[1]));
    pll_bus_freq_calc #(.LAYOUT(LAYOUT_C), .FORCE_25M(1'b1)) dut_c (
        .clk(clk), .rst(rst), .start(start), .pll_word(pw), .clksel_word(cw),
        .strap_word(sw), .pll_hz(ph[2]), .bus_hz(bh[2]), .done(dn[2]));

    typedef struct packed {
        logic [31:0] p;
        logic [31:0] c;
        logic [31:0] s;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{32'h0200_0BE3, 32'h0080_0000, 32'h0000_0000, 4'd3},  // R3 power-down
        '{32'h0100_0BE3, 32'h0000_0000, 32'h0004_0000, 4'd4},  // R4 bypass
        '{32'h0180_0123, 32'h0080_0000, 32'h0000_0000, 4'd4},  // R4 bypass+prog
        '{32'h0000_0BE3, 32'h0080_0000, 32'h0000_0000, 4'd5},  // R5 plain ratio
        '{32'h0000_2122, 32'h0000_0000, 32'h0004_0000, 4'd5},  // R5 truncation
        '{32'h0010_2257, 32'h0100_0000, 32'h0080_0000, 4'd6},  // R6 C fields
        '{32'h0080_0291, 32'h0000_0000, 32'h0000_0000, 4'd7},  // R7 od=1
        '{32'h0080_03C2, 32'h0080_0000, 32'h0004_0000, 4'd7},  // R7 od=0
        '{32'h0000_0000, 32'h0000_0000, 32'h0080_0300, 4'd8},  // R8 row 1 sel 3
        '{32'h0000_0000, 32'h0080_0000, 32'h0004_0200, 4'd8},  // R8 row 0 sel 2
        '{32'h0000_0BE3, 32'h0380_0000, 32'h0000_0000, 4'd9},  // R9 max divider
        '{32'h0180_0000, 32'h0000_0000, 32'h0084_0000, 4'd2}   // R2 both straps
    };

    function automatic string tag(input logic [3:0] r);
        case (r)
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic logic [31:0] tbl(input logic row, input logic [1:0] s);
        case ({row, s})
            3'd0: return 32'd384; 3'd1: return 32'd360;
            3'd2: return 32'd336; 3'd3: return 32'd408;
            3'd4: return 32'd400; 3'd5: return 32'd375;
            3'd6: return 32'd350; default: return 32'd425;
        endcase
    endfunction

    // Reference model written from the requirements.
    task automatic model(input int lay, input bit f25, input logic [31:0] p,
                         input logic [31:0] c, input logic [31:0] s,
                         output logic [31:0] ep, output logic [31:0] eb);
        logic [31:0] rf, a, b, d, q;
        rf = (s[23] || f25) ? 32'd25_000_000 : (s[18] ? 32'd48_000_000 : 32'd24_000_000);
        if (p[25]) ep = 0;
        else if (lay == 0) begin
            if (!p[23]) ep = tbl(s[23], s[9:8]) * 32'd1_000_000;
            else if (p[24]) ep = rf;
            else begin
                q = (32'(p[10:5]) + 2) / (32'(p[3:0]) + 1);
                ep = rf * ((p[4] ? 32'd1 : 32'd2) * q);
            end
        end else if (p[24]) ep = rf;
        else begin
            if (lay == 1) begin
                a = 32'(p[12:5]); b = 32'(p[4:0]); d = 32'(p[18:13]);
            end else begin
                a = 32'(p[12:0]); b = 32'(p[18:13]); d = 32'(p[22:19]);
            end
            q = ((a + 1) / (b + 1)) / (d + 1);
            ep = rf * q;
        end
        eb = (ep / (32'(c[25:23]) + 1)) / ((lay == 0) ? 32'd2 : 32'd4);
    endtask

    task automatic check(input string t, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", t, what, got, exp);
        end
    endtask

    // Launch with one set of words, optionally present a second start mid-run,
    // wait for all three done pulses and check them against the model.
    task automatic run(input logic [31:0] p, input logic [31:0] c, input logic [31:0] s,
                       input string t, input bit stray);
        bit          seen [3];
        int          at [3];
        int          cnt [3];
        logic [31:0] ep, eb;
        @(negedge clk);
        pw = p; cw = c; sw = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 3; k++) begin seen[k] = 0; at[k] = -10; cnt[k] = 0; end
        for (int i = 0; i < 600; i++) begin
            if (stray && i == 5) begin
                pw = 32'h0000_0000; cw = 32'h0380_0000; sw = 32'h0080_0100; start = 1'b1;
            end else start = 1'b0;
            @(negedge clk);
            for (int k = 0; k < 3; k++) begin
                if (at[k] == i - 1)
                    check("R10", "done width", {31'd0, dn[k]}, 32'd0);
                if (dn[k]) begin
                    cnt[k]++;
                    if (!seen[k]) begin
                        seen[k] = 1; at[k] = i;
                        model(k, k == 2, p, c, s, ep, eb);
                        check(t, $sformatf("pll_hz layout %0d", k), ph[k], ep);
                        check(t, $sformatf("bus_hz layout %0d", k), bh[k], eb);
                    end
                end
            end
        end
        start = 1'b0;
        for (int k = 0; k < 3; k++)
            check(stray ? "R11" : "R10", $sformatf("done count layout %0d", k), cnt[k], 32'd1);
        if (stray) begin
            for (int k = 0; k < 3; k++) begin
                model(k, k == 2, p, c, s, ep, eb);
                check("R11", "held pll_hz", ph[k], ep);
                check("R11", "held bus_hz", bh[k], eb);
            end
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin // R1 reset state
            check("R1", "pll_hz", ph[k], 32'd0);
            check("R1", "bus_hz", bh[k], 32'd0);
            check("R1", "done", {31'd0, dn[k]}, 32'd0);
        end
        for (int v = 0; v < NV; v++)
            run(VECS[v].p, VECS[v].c, VECS[v].s, tag(VECS[v].req), 1'b0);

        // Hand-derived values for layout B (instance dut, index 1).
        run(32'h0000_0BE3, 32'h0080_0000, 32'h0, "R5", 1'b0);
        check("R5", "hand pll_hz", ph[1], 32'd576_000_000);
        check("R9", "hand bus_hz", bh[1], 32'd72_000_000);
        run(32'h0000_2122, 32'h0, 32'h0004_0000, "R5", 1'b0);
        check("R5", "truncated stages", ph[1], 32'd48_000_000);
        // Hand-derived table value for layout A.
        run(32'h0, 32'h0, 32'h0080_0300, "R8", 1'b0);
        check("R8", "table 425 MHz", ph[0], 32'd425_000_000);
        check("R9", "layout A divide by 2", bh[0], 32'd212_500_000);

        // Second start during a calculation must be ignored.
        run(32'h0000_0BE3, 32'h0080_0000, 32'h0000_0000, "R11", 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule